// File: doc/BRIEF.md
# Configuration Capability List Walker

This engine searches one function's configuration space for a requested capability and reports where that capability sits. A search begins with a one-cycle `start` pulse. The pulse carries a list selector and a 16-bit capability identifier. The engine then issues dword reads, one at a time, on a request/acknowledge read port. It follows the chain of next pointers until one of four things happens: an entry matches, the chain ends, a hop bound runs out, or a read returns all ones. A one-cycle `done` pulse then presents the outcome: `found` with the entry's byte `offset`, not found, `err_absent`, or `err_loop`.

The space holds two lists. The `sel_ext` input chooses which one to walk, because the two lists reuse the same identifier numbers.

- **Legacy list.** It lives in the 192 bytes above the 64-byte header. Each entry has a byte-wide identifier and a byte-wide next pointer. The engine walks it only when the capabilities flag in the status half of dword 0x04 is set.
- **Extended list.** It always starts at byte 0x100. Each header dword has a 16-bit identifier, a 4-bit version and a 12-bit next offset.

States:

- `ST_IDLE` waits for `start`.
- `ST_STATUS` reads dword 0x004.
- `ST_CAPPTR` reads dword 0x034.
- `ST_LEGACY` reads legacy entries.
- `ST_EXTENDED` reads extended headers.
- `ST_DONE` presents the result for one cycle.

Transitions:

- **launch:** `ST_IDLE` goes to `ST_STATUS` or `ST_EXTENDED` on `start`.
- **gate pass:** `ST_STATUS` goes to `ST_CAPPTR` when the flag is set.
- **enter:** `ST_CAPPTR` goes to `ST_LEGACY` when the pointer is in range.
- **hop:** `ST_LEGACY` or `ST_EXTENDED` moves to the next entry and stays in the same state.
- **finish:** any read state goes to `ST_DONE` on an acknowledged read that ends the walk.
- **retire:** `ST_DONE` goes to `ST_IDLE`.

Top module: `cap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req`, `found`, `err_absent` and `err_loop` are all 0.
- R2: A legacy search first reads byte address 0x004. If bit 20 of that dword (bit 4 of its upper, status half) is 0, the walk ends as not found after that single read.
- R3: Each read holds `rd_req` high with a dword-aligned `rd_addr` (bits 1:0 zero). The address stays unchanged until `rd_ack`, and each acknowledge consumes exactly one read.
- R4: The first legacy entry is taken from bits 7:0 of the dword at 0x034, with bits 1:0 forced to zero. In an entry, bits 7:0 hold the identifier and bits 15:8 hold the next pointer, which is masked the same way. Only `want_id[7:0]` is compared, and a match reports the entry's byte address on `offset`.
- R5: A legacy pointer below 0x40 (zero included) ends the walk as not found, without reading there.
- R6: An extended walk starts at 0x100. Bits 15:0 hold the identifier and are compared with all 16 bits of `want_id`. Bits 19:16 (the version) are ignored. Bits 31:20 hold the next offset, with bits 1:0 forced to zero.
- R7: An extended header dword of all zeros, or a next offset below 0x100, ends the walk as not found.
- R8: A read returning 0xFFFFFFFF ends the walk at once with `err_absent` = 1 and `found` = 0. At most one of `found`, `err_absent` and `err_loop` is ever set.
- R9: If 48 legacy entries or 960 extended headers have been read without a match and the chain still continues, the walk ends with `err_loop` = 1.
- R10: `done` is high for exactly one cycle, in the cycle after the final `rd_ack`. The results hold until the next accepted `start`, and a `start` pulse while `busy` is ignored.
- R11: `sel_ext` = 0 walks the legacy list and `sel_ext` = 1 walks the extended list, so the same identifier can give different results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| sel_ext | input | 1 | 0: legacy list, 1: extended list |
| want_id | input | 16 | Capability identifier to find |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Capability located |
| offset | output | 12 | Byte address of the matching entry |
| err_absent | output | 1 | A read returned all ones |
| err_loop | output | 1 | Hop bound reached |
| rd_req | output | 1 | Configuration read request |
| rd_addr | output | 12 | Dword-aligned byte address of the read |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |

## Verification
After an accepted `start`, `busy` goes high on the following clock edge. Each read produces one `rd_ack`, and the results come out with `done` exactly one cycle after the last acknowledge. The bench counts acknowledges and records the cycle of the last one. When `done` appears, it checks both the number of reads the behavioural walk predicts and the one-cycle gap. Outputs are sampled on the falling edge. Every falling edge also checks that the read address holds while a request is outstanding and that `busy` stays high through the whole walk.

// File: rtl/cap_walk_pkg.sv
`timescale 1ns/1ps
package cap_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STATUS,
        ST_CAPPTR,
        ST_LEGACY,
        ST_EXTENDED,
        ST_DONE
    } walk_state_t;

    localparam int          ADDR_W          = 12;
    localparam int          DATA_W          = 32;
    localparam int          ID_W            = 16;
    localparam logic [11:0] STATUS_ADDR     = 12'h004;
    localparam logic [11:0] CAPPTR_ADDR     = 12'h034;
    localparam logic [11:0] LEGACY_FLOOR    = 12'h040;
    localparam logic [11:0] EXT_BASE        = 12'h100;
    localparam int          CAP_PRESENT_BIT = 20;

endpackage

// File: rtl/cap_hdr_decode.sv
`timescale 1ns/1ps
module cap_hdr_decode
    import cap_walk_pkg::*;
(
    input  logic              ext_mode,
    input  logic [DATA_W-1:0] dword,
    output logic [ID_W-1:0]   cap_id,
    output logic [ADDR_W-1:0] next_ptr,
    output logic              next_ok,
    output logic              all_ones,
    output logic              empty
);

    always_comb begin
        all_ones = &dword;
        if (ext_mode) begin
            cap_id   = dword[15:0];
            next_ptr = {dword[31:22], 2'b00};
            next_ok  = next_ptr >= EXT_BASE;
            empty    = dword == '0;
        end else begin
            cap_id   = {8'h00, dword[7:0]};
            next_ptr = {4'h0, dword[15:10], 2'b00};
            next_ok  = next_ptr >= LEGACY_FLOOR;
            empty    = 1'b0;
        end
    end

endmodule

// File: rtl/walk_hop_counter.sv
`timescale 1ns/1ps
module walk_hop_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    assign last = cnt == limit;

    // step is issued by the walker only while the bound is not yet reached
    assert_hops_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> cnt < limit);

endmodule

// File: rtl/cap_walker.sv
`timescale 1ns/1ps
module cap_walker
    import cap_walk_pkg::*;
#(
    parameter int LEG_HOPS = 48,
    parameter int EXT_HOPS = 960
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sel_ext,
    input  logic [15:0] want_id,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [11:0] offset,
    output logic        err_absent,
    output logic        err_loop,
    output logic        rd_req,
    output logic [11:0] rd_addr,
    input  logic        rd_ack,
    input  logic [31:0] rd_data
);

    localparam int MAX_HOPS = (EXT_HOPS > LEG_HOPS) ? EXT_HOPS : LEG_HOPS;
    localparam int HOP_W    = $clog2(MAX_HOPS + 1);

    walk_state_t       state, nxt;
    logic [ADDR_W-1:0] cur_addr, new_addr;
    logic              sel_q;
    logic [ID_W-1:0]   id_q;

    logic              fin, fin_found, fin_abs, fin_loop;
    logic              hop_clr, hop_step, hop_last;
    logic [HOP_W-1:0]  hop_lim;

    logic [ID_W-1:0]   dec_id;
    logic [ADDR_W-1:0] dec_next;
    logic              dec_next_ok, dec_all_ones, dec_empty, id_match;
    logic [ADDR_W-1:0] capptr;

    cap_hdr_decode u_decode (
        .ext_mode (sel_q),
        .dword    (rd_data),
        .cap_id   (dec_id),
        .next_ptr (dec_next),
        .next_ok  (dec_next_ok),
        .all_ones (dec_all_ones),
        .empty    (dec_empty)
    );

    assign hop_lim = sel_q ? HOP_W'(EXT_HOPS - 1) : HOP_W'(LEG_HOPS - 1);

    walk_hop_counter #(.CNT_W(HOP_W)) u_hops (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hop_clr),
        .step  (hop_step),
        .limit (hop_lim),
        .last  (hop_last)
    );

    assign id_match = sel_q ? (dec_id == id_q) : (dec_id[7:0] == id_q[7:0]);
    assign capptr   = {4'h0, rd_data[7:2], 2'b00};

    // next-state and walk decisions
    always_comb begin
        nxt       = state;
        new_addr  = cur_addr;
        hop_clr   = 1'b0;
        hop_step  = 1'b0;
        fin       = 1'b0;
        fin_found = 1'b0;
        fin_abs   = 1'b0;
        fin_loop  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    hop_clr = 1'b1;
                    if (sel_ext) begin
                        nxt      = ST_EXTENDED;
                        new_addr = EXT_BASE;
                    end else begin
                        nxt      = ST_STATUS;
                        new_addr = STATUS_ADDR;
                    end
                end
            end
            ST_STATUS: begin
                if (rd_ack) begin
                    if (dec_all_ones) begin
                        fin     = 1'b1;
                        fin_abs = 1'b1;
                    end else if (!rd_data[CAP_PRESENT_BIT]) begin
                        fin = 1'b1;
                    end else begin
                        nxt      = ST_CAPPTR;
                        new_addr = CAPPTR_ADDR;
                    end
                end
            end
            ST_CAPPTR: begin
                if (rd_ack) begin
                    if (dec_all_ones) begin
                        fin     = 1'b1;
                        fin_abs = 1'b1;
                    end else if (capptr < LEGACY_FLOOR) begin
                        fin = 1'b1;
                    end else begin
                        nxt      = ST_LEGACY;
                        new_addr = capptr;
                    end
                end
            end
            ST_LEGACY, ST_EXTENDED: begin
                if (rd_ack) begin
                    if (dec_all_ones) begin
                        fin     = 1'b1;
                        fin_abs = 1'b1;
                    end else if (dec_empty) begin
                        fin = 1'b1;
                    end else if (id_match) begin
                        fin       = 1'b1;
                        fin_found = 1'b1;
                    end else if (!dec_next_ok) begin
                        fin = 1'b1;
                    end else if (hop_last) begin
                        fin      = 1'b1;
                        fin_loop = 1'b1;
                    end else begin
                        hop_step = 1'b1;
                        new_addr = dec_next;
                    end
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (fin) nxt = ST_DONE;
    end

    // state register, walk context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            sel_q      <= 1'b0;
            id_q       <= '0;
            found      <= 1'b0;
            offset     <= '0;
            err_absent <= 1'b0;
            err_loop   <= 1'b0;
        end else begin
            state    <= nxt;
            cur_addr <= new_addr;
            if (state == ST_IDLE && start) begin
                sel_q      <= sel_ext;
                id_q       <= want_id;
                found      <= 1'b0;
                offset     <= '0;
                err_absent <= 1'b0;
                err_loop   <= 1'b0;
            end else if (fin) begin
                found      <= fin_found;
                offset     <= fin_found ? cur_addr : '0;
                err_absent <= fin_abs;
                err_loop   <= fin_loop;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy    = state != ST_IDLE;
        done    = state == ST_DONE;
        rd_req  = state inside {ST_STATUS, ST_CAPPTR, ST_LEGACY, ST_EXTENDED};
        rd_addr = cur_addr;
    end

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_addr[1:0] == 2'b00);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    assert_legacy_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && state == ST_LEGACY |-> rd_addr >= LEGACY_FLOOR && rd_addr < EXT_BASE);

    assert_ext_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && state == ST_EXTENDED |-> rd_addr >= EXT_BASE);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({found, err_absent, err_loop}));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(found) && $stable(offset) && $stable(err_absent)
                            && $stable(err_loop));

endmodule

// File: tb/cap_walker_bench.sv
`timescale 1ns/1ps
module cap_walker_bench;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sel_ext = 1'b0;
    logic [15:0] want_id = '0;
    logic        busy, done, found, err_absent, err_loop, rd_req;
    logic [11:0] offset, rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;

    logic [31:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int last_ack_cyc = -10;
    int lat_cnt = 0;
    bit walking = 1'b0;
    bit prev_req = 1'b0;
    bit prev_ack = 1'b0;
    logic [11:0] prev_addr = '0;

    always #2 clk = ~clk;

    cap_walker u_cap_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_ext(sel_ext), .want_id(want_id),
        .busy(busy), .done(done), .found(found), .offset(offset),
        .err_absent(err_absent), .err_loop(err_loop),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    // configuration space responder with fixed latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_ack) ack_cnt <= ack_cnt + 1;
        if (!rst_n) begin
            rd_ack  <= 1'b0;
            lat_cnt <= 0;
        end else if (rd_ack) begin
            rd_ack <= 1'b0;
        end else if (rd_req) begin
            if (lat_cnt == LAT) begin
                rd_ack  <= 1'b1;
                rd_data <= mem[rd_addr[11:2]];
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the expected cycle behaviour
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req && !prev_ack && rd_req)
                check(rd_addr == prev_addr, "R3", "address held while waiting", rd_addr, prev_addr);
            if (rd_req)
                check(rd_addr[1:0] == 2'b00, "R3", "dword aligned", rd_addr, rd_addr & 12'hffc);
            if (walking)
                check(busy, "R10", "busy during walk", busy, 1);
            if (done)
                check(last_ack_cyc == cyc - 1, "R10", "done one cycle after last ack",
                      cyc - last_ack_cyc, 1);
            if (rd_ack) last_ack_cyc = cyc;
        end
        prev_req  = rd_req;
        prev_ack  = rd_ack;
        prev_addr = rd_addr;
    end

    // behavioural walk used as the expected result
    function automatic void ref_walk(input bit ext, input logic [15:0] id,
                                     output bit f, output int off, output bit ab,
                                     output bit lp, output int nrd);
        logic [31:0] d;
        int p, n;
        f = 0; off = 0; ab = 0; lp = 0; nrd = 0;
        if (!ext) begin
            nrd = 1; d = mem[1];
            if (d == 32'hffffffff) begin ab = 1; return; end
            if (!d[20]) return;
            nrd = 2; d = mem[13];
            if (d == 32'hffffffff) begin ab = 1; return; end
            p = d[7:0] & 8'hfc;
            if (p < 64) return;
            for (int v = 1; v <= 2000; v++) begin
                nrd++; d = mem[p / 4];
                if (d == 32'hffffffff) begin ab = 1; return; end
                if (d[7:0] == id[7:0]) begin f = 1; off = p; return; end
                n = d[15:8] & 8'hfc;
                if (n < 64) return;
                if (v == 48) begin lp = 1; return; end
                p = n;
            end
        end else begin
            p = 256;
            for (int v = 1; v <= 2000; v++) begin
                nrd++; d = mem[p / 4];
                if (d == 32'hffffffff) begin ab = 1; return; end
                if (d == 0) return;
                if (d[15:0] == id) begin f = 1; off = p; return; end
                n = (d >> 20) & 12'hffc;
                if (n < 256) return;
                if (v == 960) begin lp = 1; return; end
                p = n;
            end
        end
    endfunction

    task automatic wait_done(string req);
        int t = 0;
        do begin @(negedge clk); t++; end while (!done && t < 8000);
        check(done, req, "done reached", done, 1);
    endtask

    task automatic run(bit ext, logic [15:0] id, string req, bit interrupt = 0);
        bit f, ab, lp; int off, nrd;
        ref_walk(ext, id, f, off, ab, lp, nrd);
        @(negedge clk);
        sel_ext = ext; want_id = id; start = 1'b1; ack_cnt = 0;
        @(negedge clk);
        start = 1'b0; walking = 1'b1;
        if (interrupt) begin
            repeat (3) @(negedge clk);
            sel_ext = ~ext; want_id = ~id; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(req);
        walking = 1'b0;
        check(found == f, req, "found", found, f);
        check(offset == 12'(off), req, "offset", offset, off);
        check(err_absent == ab, req, "err_absent", err_absent, ab);
        check(err_loop == lp, req, "err_loop", err_loop, lp);
        check(ack_cnt == nrd, req, "read count", ack_cnt, nrd);
        @(negedge clk);
        check(!done, "R10", "done single cycle", done, 0);
        repeat (2) @(negedge clk);
        check(found == f && offset == 12'(off), "R10", "result held", offset, off);
    endtask

    task automatic base_space();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[1]  = 32'h0010_0000;
        mem[13] = 32'h0000_0041;
        mem[16] = 32'h0000_5001;
        mem[20] = 32'h0000_7205;
        mem[28] = 32'h0000_0010;
        mem[64] = 32'h1401_0001;
        mem[80] = 32'h2002_0010;
        mem[128] = 32'h0003_000B;
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin @(posedge clk); wd++; end
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        base_space();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "idle after reset", {busy, done, rd_req}, 0);
        check(!found && !err_absent && !err_loop, "R1", "results clear", {found, err_absent, err_loop}, 0);

        // R4 legacy hits, upper id byte ignored, masked pointers
        run(1'b0, 16'h0010, "R4");
        run(1'b0, 16'hAB05, "R4");
        run(1'b0, 16'h0001, "R4");
        // R5 end of legacy chain and low pointer
        run(1'b0, 16'h0099, "R5");
        mem[13] = 32'h0000_0020;
        run(1'b0, 16'h0001, "R5");
        mem[13] = 32'h0000_0041;
        // R2 capabilities flag clear
        mem[1] = 32'h00EF_0000;
        run(1'b0, 16'h0010, "R2");
        mem[1] = 32'h0010_0000;
        // R6 extended hits, version ignored, full id compare
        run(1'b1, 16'h0010, "R6");
        run(1'b1, 16'h000B, "R6");
        run(1'b1, 16'hAB10, "R6");
        // R11 same identifier on the other list
        run(1'b1, 16'h0001, "R11");
        run(1'b0, 16'h0001, "R11");
        // R7 extended end conditions
        mem[64] = 32'h0801_0001;
        run(1'b1, 16'h0010, "R7");
        mem[64] = '0;
        run(1'b1, 16'h0000, "R7");
        // R8 all-ones reads
        base_space();
        mem[1] = 32'hFFFF_FFFF;
        run(1'b0, 16'h0010, "R8");
        base_space();
        mem[20] = 32'hFFFF_FFFF;
        run(1'b0, 16'h0010, "R8");
        mem[64] = 32'hFFFF_FFFF;
        run(1'b1, 16'h0001, "R8");
        // R9 circular lists
        base_space();
        mem[16] = 32'h0000_4007;
        run(1'b0, 16'h0009, "R9");
        mem[64] = 32'h1001_0002;
        run(1'b1, 16'h0003, "R9");
        // R10 start while busy is ignored
        base_space();
        run(1'b0, 16'h0010, "R10", 1'b1);
        run(1'b1, 16'h000B, "R10", 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule